// File: doc/BRIEF.md
# Snoop Phase Result Resolver

On a shared multi-agent processor bus, every caching agent drives its snoop response onto two wired-OR lines, `hit` and `hitm`. The memory or I/O target drives a third wired-OR line that says whether completion is committed now or deferred. The requesting agent snoops its own transaction, so its response is already part of the OR. This block follows one transaction at a time. It registers the three lines on each snoop-window strobe and decodes the combined code. It then reports a single resolved result.

The result tells the requester four things. The first is the snoop outcome. The second is whether it may install the line exclusive, which is allowed only when no other cache holds the line. The third is whether a modified-line owner, rather than memory, will supply the data. The fourth is whether completion was deferred. The stall combination carries no result, so the block waits for the next strobe, and it raises a timeout flag if stalls keep coming. Non-memory transactions produce no snoop response; the block answers them at once with a forced clean result. A transaction cancelled by an address error while its snoop is pending is dropped without a result.

Top module: `snoop_resolver`

## Requirements
- R1: After reset, resultValid and stallTimeout are 0 and the block waits for a transaction start.
- R2: On a valid result, resultCode equals {hit, hitm} as registered at the delivering strobe: 2'b00 clean (no other cache holds the line), 2'b01 modified (a cache holds it dirty), 2'b10 shared.
- R3: For a memory transaction, a non-stall strobe in cycle N makes resultValid high in cycle N+1 only. resultValid is low in every other cycle. While resultValid is low, dataFromOwner, grantExclusive and deferred are 0.
- R4: dataFromOwner is 1 exactly when a valid result has code modified.
- R5: grantExclusive is 1 exactly when a valid memory-transaction result has code clean.
- R6: deferred equals the defer line registered together with the delivering strobe.
- R7: The stall code 2'b11 yields no result. The block stays waiting, and the next strobe is sampled afresh.
- R8: stallTimeout rises two cycles after the 16th consecutive stall strobe of a transaction and is still 0 after 15. It stays set until the transaction ends with a result or an abort, and then clears on the next edge.
- R9: A transaction start with txnIsMem=0 gives resultValid in the next cycle, with code clean and dataFromOwner, grantExclusive and deferred all 0. No strobe is needed.
- R10: addrErr while waiting for a snoop, with no strobe in the previous cycle, drops the transaction. No result follows, and later strobes are ignored until a new start.
- R11: Strobes while no transaction is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | One-cycle pulse that opens a transaction |
| txnIsMem | input | 1 | Transaction is a memory access (qualifies txnStart) |
| addrErr | input | 1 | Address-error abort of the pending transaction |
| snoopStrobe | input | 1 | Snoop window: sample the three lines this cycle |
| hitIn | input | 1 | Wired-OR hit line, active high |
| hitmIn | input | 1 | Wired-OR modified-hit line, active high |
| deferIn | input | 1 | Wired-OR defer line from the target, active high |
| resultValid | output | 1 | Resolved result present this cycle |
| resultCode | output | 2 | Resolved snoop code |
| dataFromOwner | output | 1 | Modified owner supplies the data |
| grantExclusive | output | 1 | Requester may take the line exclusive |
| deferred | output | 1 | Completion is deferred |
| stallTimeout | output | 1 | Too many consecutive stalls on this transaction |

## Verification
Each result is due at a fixed cycle. A non-stall snoop result appears in the cycle after the strobe that carried it. A non-memory answer appears in the cycle after the start pulse. The timeout flag appears two cycles after the sixteenth stall strobe. Inputs are driven one time unit after a rising edge and outputs are read at that same point, so every check counts whole edges from its stimulus. Each check also looks at the cycle after a result, to confirm that resultValid has fallen and that later strobes have no effect.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    SNP_CLEAN    = 2'b00,
    SNP_MODIFIED = 2'b01,
    SNP_SHARED   = 2'b10,
    SNP_STALL    = 2'b11
  } snoopCode_e;

  typedef struct packed {
    logic capture;     // register the bus lines this cycle
    logic forceClean;  // answer a non-memory transaction
  } snoopCtl_t;
endpackage

// File: rtl/snoop_dpath.sv
module snoop_dpath
  import snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  snoopCtl_t  ctl,
  input  logic       hitIn,
  input  logic       hitmIn,
  input  logic       deferIn,
  output logic       sampValid,
  output logic       sampStall,
  output logic       resultValid,
  output logic [1:0] resultCode,
  output logic       dataFromOwner,
  output logic       grantExclusive,
  output logic       deferred
);
  localparam int LINES = 3;

  logic [LINES-1:0] busIn;
  logic [LINES-1:0] sampReg;
  logic             forceValid;
  snoopCode_e       sampCode;
  logic             memResult;

  assign busIn = {deferIn, hitIn, hitmIn};

  for (genvar i = 0; i < LINES; i++) begin : g_samp
    always_ff @(posedge clk) begin
      if (!rstN)            sampReg[i] <= 1'b0;
      else if (ctl.capture) sampReg[i] <= busIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampValid  <= 1'b0;
      forceValid <= 1'b0;
    end else begin
      sampValid  <= ctl.capture;
      forceValid <= ctl.forceClean;
    end
  end

  assign sampCode  = snoopCode_e'(sampReg[1:0]);
  assign sampStall = (sampCode == SNP_STALL);
  assign memResult = sampValid && !sampStall;

  always_comb begin
    resultValid    = memResult || forceValid;
    resultCode     = memResult ? sampCode : SNP_CLEAN;
    dataFromOwner  = memResult && (sampCode == SNP_MODIFIED);
    grantExclusive = memResult && (sampCode == SNP_CLEAN);
    deferred       = memResult && sampReg[2];
  end

  p_owner_modified_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataFromOwner |-> (resultValid && resultCode == SNP_MODIFIED));
  p_excl_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
    grantExclusive |-> (resultValid && resultCode == SNP_CLEAN));
  p_no_stall_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultCode != SNP_STALL));
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int STALL_LIMIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txnStart,
  input  logic      txnIsMem,
  input  logic      addrErr,
  input  logic      snoopStrobe,
  input  logic      sampValid,
  input  logic      sampStall,
  output snoopCtl_t ctl,
  output logic      stallTimeout
);
  localparam int CNT_W = $clog2(STALL_LIMIT + 1);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e           state, stateNxt;
  logic [CNT_W-1:0] stallCnt;
  logic             resultDone, finish, stallSeen;

  assign resultDone = (state == ST_WAIT) && sampValid && !sampStall;
  assign finish     = (state == ST_WAIT) && (addrErr || resultDone);
  assign stallSeen  = (state == ST_WAIT) && sampValid && sampStall;

  always_comb begin
    ctl.capture    = (state == ST_WAIT) && snoopStrobe && !addrErr && !resultDone;
    ctl.forceClean = (state == ST_IDLE) && txnStart && !txnIsMem;
    stateNxt       = state;
    case (state)
      ST_IDLE: if (txnStart && txnIsMem) stateNxt = ST_WAIT;
      ST_WAIT: if (finish)               stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      stallCnt     <= '0;
      stallTimeout <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE || finish) begin
        stallCnt     <= '0;
        stallTimeout <= 1'b0;
      end else if (stallSeen) begin
        if (stallCnt != CNT_W'(STALL_LIMIT)) stallCnt <= stallCnt + 1'b1;
        if (stallCnt == CNT_W'(STALL_LIMIT - 1)) stallTimeout <= 1'b1;
      end
    end
  end

  p_timeout_after_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallTimeout) |-> $past(sampStall && sampValid));
  p_idle_no_capture_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !ctl.capture);
endmodule

// File: rtl/snoop_resolver.sv
module snoop_resolver
  import snoop_pkg::*;
#(
  parameter int STALL_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txnStart,
  input  logic       txnIsMem,
  input  logic       addrErr,
  input  logic       snoopStrobe,
  input  logic       hitIn,
  input  logic       hitmIn,
  input  logic       deferIn,
  output logic       resultValid,
  output logic [1:0] resultCode,
  output logic       dataFromOwner,
  output logic       grantExclusive,
  output logic       deferred,
  output logic       stallTimeout
);
  snoopCtl_t ctl;
  logic      sampValid, sampStall;

  snoop_ctrl #(.STALL_LIMIT(STALL_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnIsMem(txnIsMem),
    .addrErr(addrErr), .snoopStrobe(snoopStrobe), .sampValid(sampValid),
    .sampStall(sampStall), .ctl(ctl), .stallTimeout(stallTimeout)
  );

  snoop_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hitIn(hitIn), .hitmIn(hitmIn),
    .deferIn(deferIn), .sampValid(sampValid), .sampStall(sampStall),
    .resultValid(resultValid), .resultCode(resultCode),
    .dataFromOwner(dataFromOwner), .grantExclusive(grantExclusive),
    .deferred(deferred)
  );

  p_strobe_before_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultCode != SNP_CLEAN) |-> $past(snoopStrobe));
  p_quiet_outputs_r3: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> !(dataFromOwner || grantExclusive || deferred));
endmodule

// File: tb/snoop_resolver_test.sv
module snoop_resolver_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnStart = 1'b0, txnIsMem = 1'b0, addrErr = 1'b0;
  logic snoopStrobe = 1'b0, hitIn = 1'b0, hitmIn = 1'b0, deferIn = 1'b0;
  logic resultValid, dataFromOwner, grantExclusive, deferred, stallTimeout;
  logic [1:0] resultCode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  snoop_resolver uut (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnIsMem(txnIsMem),
    .addrErr(addrErr), .snoopStrobe(snoopStrobe), .hitIn(hitIn), .hitmIn(hitmIn),
    .deferIn(deferIn), .resultValid(resultValid), .resultCode(resultCode),
    .dataFromOwner(dataFromOwner), .grantExclusive(grantExclusive),
    .deferred(deferred), .stallTimeout(stallTimeout)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // full output vector {valid, code, owner, excl, deferred}
  function automatic int outVec();
    return {resultValid, resultCode, dataFromOwner, grantExclusive, deferred};
  endfunction

  function automatic int expVec(bit v, bit [1:0] c, bit o, bit e, bit d);
    return {v, c, o, e, d};
  endfunction

  task automatic startMem();
    txnStart = 1; txnIsMem = 1; tick(); txnStart = 0; txnIsMem = 0;
  endtask

  task automatic strobe(bit h, bit hm, bit d);
    snoopStrobe = 1; hitIn = h; hitmIn = hm; deferIn = d; tick();
    snoopStrobe = 0; hitIn = 0; hitmIn = 0; deferIn = 0;
  endtask

  // R2 R3 R4 R5 R6: one full memory snoop with given lines
  task automatic memSnoop(string req, bit h, bit hm, bit d);
    startMem();
    tick();
    check("R3", "no result before strobe", resultValid, 0);
    strobe(h, hm, d);
    check(req, "result vector", outVec(),
          expVec(1, {h, hm}, ~h & hm, ~h & ~hm, d));
    tick();
    check("R3", "valid falls after one cycle", outVec(), 0);
  endtask

  task automatic testReset();
    check("R1", "resultValid at reset", resultValid, 0);
    check("R1", "stallTimeout at reset", stallTimeout, 0);
  endtask

  task automatic testIdleStrobe();
    strobe(0, 1, 1);
    check("R11", "idle strobe no result", outVec(), 0);
    tick();
    check("R11", "idle strobe no result later", outVec(), 0);
  endtask

  task automatic testNonMem();
    txnStart = 1; txnIsMem = 0; hitmIn = 1; tick();
    txnStart = 0; hitmIn = 0;
    check("R9", "non-memory clean", outVec(), expVec(1, 2'b00, 0, 0, 0));
    tick();
    check("R9", "non-memory single cycle", resultValid, 0);
  endtask

  task automatic testStallThenResult();
    startMem();
    strobe(1, 1, 0);
    check("R7", "stall gives no result", resultValid, 0);
    tick();
    check("R7", "still waiting", resultValid, 0);
    strobe(1, 0, 1);
    check("R7", "resample after stall", outVec(), expVec(1, 2'b10, 0, 0, 1));
    tick();
  endtask

  task automatic testTimeout();
    startMem();
    for (int i = 0; i < 15; i++) strobe(1, 1, 0);
    tick(); tick();
    check("R8", "no timeout after 15 stalls", stallTimeout, 0);
    strobe(1, 1, 0);
    check("R8", "no timeout one cycle after 16th", stallTimeout, 0);
    tick();
    check("R8", "timeout after 16 stalls", stallTimeout, 1);
    tick();
    check("R8", "timeout held", stallTimeout, 1);
    strobe(0, 1, 0);
    check("R8", "result after timeout", outVec(), expVec(1, 2'b01, 1, 0, 0));
    tick();
    check("R8", "timeout cleared at end", stallTimeout, 0);
  endtask

  task automatic testAbort();
    startMem();
    tick();
    addrErr = 1; tick(); addrErr = 0;
    check("R10", "abort no result", resultValid, 0);
    strobe(0, 0, 0);
    check("R10", "strobe after abort ignored", outVec(), 0);
    tick();
    check("R10", "still no result", outVec(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    tick(); tick();
    testReset();
    rstN = 1;
    tick();
    testReset();
    testIdleStrobe();
    memSnoop("R2", 0, 0, 0);
    memSnoop("R4", 0, 1, 0);
    memSnoop("R5", 1, 0, 0);
    memSnoop("R6", 0, 0, 1);
    memSnoop("R6", 0, 1, 1);
    testNonMem();
    testStallThenResult();
    testTimeout();
    testAbort();
    memSnoop("R2", 1, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule